// File: doc/BRIEF.md
# Key Matrix Change-Event Encoder

This block watches an 8-row by 12-column switch matrix and reports only the keys whose state has changed. It drives one row at a time, captures the column lines into a frame buffer, and then walks the 96 key positions in ascending order. For each position it compares the new frame with the previous frame and with the last reported state. A key whose new level has held for two whole scans, and which is not hidden by a ghost rectangle, produces one 8-bit event code. That code goes into an 8-entry queue.

The host sees `evt_irq` while the queue holds events. It reads the head from `evt_code` and removes it with a one-cycle `evt_pop` strobe. When two consecutive scans find no key down, the scanner parks in a sleep state that drives every row at once. Any column activity then restarts scanning. `half_rate` doubles the time each row is driven.

States of the scan controller:
- `ST_SLEEP`: every row is driven and the block waits for column activity.
- `ST_SCAN`: rows are driven one at a time and the columns are sampled.
- `ST_EVAL`: one key position is compared per cycle and events are queued.

Transitions:
- Reset leads to `ST_SLEEP`.
- `ST_SLEEP` goes to `ST_SCAN` when any column is high.
- `ST_SCAN` goes to `ST_EVAL` after the last row is sampled.
- `ST_EVAL` goes to `ST_SLEEP` after key 95 when the new frame and the previous frame are both empty. Otherwise it goes back to `ST_SCAN`.

Top module: `kme_encoder`

## Requirements
- R1: During scanning, `row_drive` is one-hot and steps through rows 0 to 7 in ascending order. The columns are sampled while each row is driven. A column bit is 1 when the key at that row and column is down.
- R2: Each event code has bit 7 = 1 for a release and 0 for a press. Bits 6:0 hold the key index row*12 + column (0 to 95).
- R3: A change is reported only after the new level is seen in two consecutive scans. A level present for a single scan produces no event.
- R4: Events found in the same scan are queued in ascending key-index order.
- R5: A key is a ghost candidate when three other down keys complete a rectangle with it: one in its own row, one in its own column, and one at the opposite corner. A ghost candidate's change is withheld and no event is made while the rectangle stands.
- R6: The queue holds 8 events. `evt_irq` is high exactly while the queue is non-empty. `evt_code` shows the oldest event, and an `evt_pop` pulse removes it.
- R7: An event that arrives with the queue full is dropped and sets `evt_overflow`. That flag stays set until reset.
- R8: With `half_rate` low each row is driven for 1 cycle. With `half_rate` high each row is driven for 2 cycles.
- R9: After two consecutive scans with no key down, the block sleeps with `row_drive` = 8'hFF. Any high column ends sleep, and row 0 is driven on the next cycle.
- R10: `evt_pop` while the queue is empty has no effect.
- R11: After reset, `row_drive` is 8'hFF, and `evt_irq` and `evt_overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock (32 kHz class) |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_rate | input | 1 | 1 selects half scan rate |
| col_in | input | 12 | Column sense lines, 1 = key down in a driven row |
| row_drive | output | 8 | Row drive lines, 1 = driven |
| evt_pop | input | 1 | Removes the oldest queued event |
| evt_code | output | 8 | Oldest queued event code |
| evt_irq | output | 1 | High while events are queued |
| evt_overflow | output | 1 | Sticky: an event was dropped |

## Verification
The bench models a diode matrix and presses keys in several patterns.

- A single key press and its release check the code format and the press/release bit.
- Two keys far apart in the same scan check the ascending order of events.
- Three corners of a rectangle followed by the fourth corner separate a correct ghost rule from plain change detection.
- A press that lasts exactly one scan, timed against row 0 while another key is held, separates debouncing from single-scan acceptance.
- Nine keys in one row fill the queue and check dropping and the sticky flag.
- Full release, idle time and a new press check sleep entry and wake-up. The dwell time of one row is compared at both scan rates.

// File: rtl/kme_pkg.sv
package kme_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_SCAN  = 2'd1,
        ST_EVAL  = 2'd2
    } scan_state_e;
endpackage

// File: rtl/kme_scan_fsm.sv
module kme_scan_fsm
    import kme_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 12,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            half_rate,
    input  logic            col_any,
    input  logic            quiet,
    output scan_state_e     state,
    output logic [RW-1:0]   row_idx,
    output logic [ROWS-1:0] row_drive,
    output logic            sample_en,
    output logic [RW-1:0]   eval_row,
    output logic [CW-1:0]   eval_col,
    output logic            eval_en,
    output logic            eval_last
);
    scan_state_e state_nx;
    logic        div;
    logic        tick;

    assign tick = !half_rate || div;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SLEEP: if (col_any) state_nx = ST_SCAN;
            ST_SCAN:  if (tick && row_idx == RW'(ROWS-1)) state_nx = ST_EVAL;
            ST_EVAL:  if (eval_last) state_nx = quiet ? ST_SLEEP : ST_SCAN;
            default:  state_nx = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SLEEP;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_idx  <= '0;
            div      <= 1'b0;
            eval_row <= '0;
            eval_col <= '0;
        end else begin
            if (state == ST_SCAN) begin
                div <= !div;
                if (tick) row_idx <= (row_idx == RW'(ROWS-1)) ? '0 : row_idx + 1'b1;
            end else begin
                div     <= 1'b0;
                row_idx <= '0;
            end
            if (state == ST_EVAL) begin
                if (eval_col == CW'(COLS-1)) begin
                    eval_col <= '0;
                    eval_row <= (eval_row == RW'(ROWS-1)) ? '0 : eval_row + 1'b1;
                end else begin
                    eval_col <= eval_col + 1'b1;
                end
            end else begin
                eval_row <= '0;
                eval_col <= '0;
            end
        end
    end

    always_comb begin
        row_drive = '0;
        sample_en = 1'b0;
        eval_en   = 1'b0;
        eval_last = 1'b0;
        unique case (state)
            ST_SLEEP: row_drive = '1;
            ST_SCAN: begin
                row_drive = ROWS'(1) << row_idx;
                sample_en = tick;
            end
            ST_EVAL: begin
                eval_en   = 1'b1;
                eval_last = (eval_row == RW'(ROWS-1)) && (eval_col == CW'(COLS-1));
            end
            default: row_drive = '1;
        endcase
    end

    p_row_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SCAN |-> $onehot(row_drive));
    p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && $past(state) == ST_SCAN && row_drive != $past(row_drive))
        |-> row_drive == ($past(row_drive) << 1));
    p_sleep_rows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SLEEP |-> row_drive == '1);
    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && col_any) |=> (state == ST_SCAN && row_idx == '0));
endmodule

// File: rtl/kme_ghost.sv
module kme_ghost #(
    parameter int ROWS = 8,
    parameter int COLS = 12,
    localparam int KEYS = ROWS * COLS,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic [KEYS-1:0] frame,
    input  logic [RW-1:0]   row,
    input  logic [CW-1:0]   col,
    output logic            ghost
);
    logic [COLS-1:0] own_row;
    logic [COLS-1:0] col_mask;
    logic [ROWS-1:0] hit;

    assign own_row  = frame[32'(row) * COLS +: COLS];
    assign col_mask = ~(COLS'(1) << col);

    for (genvar r = 0; r < ROWS; r++) begin : g_rect
        logic [COLS-1:0] other_row;
        assign other_row = frame[r*COLS +: COLS];
        assign hit[r] = (RW'(r) != row) && other_row[col]
                        && (|(other_row & own_row & col_mask));
    end

    assign ghost = |hit;
endmodule

// File: rtl/kme_fifo.sv
module kme_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         overflow
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          full, do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
            if (push && full) overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (overflow && $stable(count)));
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overflow) |-> overflow);
    p_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/kme_encoder.sv
module kme_encoder
    import kme_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 12,
    parameter int DEPTH = 8,
    localparam int KEYS   = ROWS * COLS,
    localparam int KW     = $clog2(KEYS),
    localparam int CODE_W = KW + 1,
    localparam int RW     = $clog2(ROWS),
    localparam int CW     = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_rate,
    input  logic [COLS-1:0]   col_in,
    output logic [ROWS-1:0]   row_drive,
    input  logic              evt_pop,
    output logic [CODE_W-1:0] evt_code,
    output logic              evt_irq,
    output logic              evt_overflow
);
    scan_state_e     state;
    logic [RW-1:0]   row_idx, eval_row;
    logic [CW-1:0]   eval_col;
    logic            sample_en, eval_en, eval_last;
    logic [KEYS-1:0] cur, prev, stable;
    logic [KW-1:0]   key;
    logic            ghost, accept, quiet, q_empty;
    logic [CODE_W-1:0] code;

    assign quiet = !(|cur) && !(|prev);
    assign key   = KW'(eval_row) * KW'(COLS) + KW'(eval_col);

    kme_scan_fsm #(.ROWS(ROWS), .COLS(COLS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .col_any(|col_in),
        .quiet(quiet), .state(state), .row_idx(row_idx), .row_drive(row_drive),
        .sample_en(sample_en), .eval_row(eval_row), .eval_col(eval_col),
        .eval_en(eval_en), .eval_last(eval_last)
    );

    kme_ghost #(.ROWS(ROWS), .COLS(COLS)) u_ghost (
        .frame(cur), .row(eval_row), .col(eval_col), .ghost(ghost)
    );

    assign accept = eval_en && (cur[key] != stable[key])
                    && (cur[key] == prev[key]) && !ghost;
    assign code   = {stable[key], key};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur    <= '0;
            prev   <= '0;
            stable <= '0;
        end else begin
            if (sample_en) cur[32'(row_idx) * COLS +: COLS] <= col_in;
            if (accept)    stable[key] <= cur[key];
            if (eval_last) prev <= cur;
        end
    end

    kme_fifo #(.W(CODE_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(accept), .din(code), .pop(evt_pop),
        .dout(evt_code), .empty(q_empty), .overflow(evt_overflow)
    );

    assign evt_irq = !q_empty;

    p_event_in_eval_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> state == ST_EVAL);
    p_debounce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> stable[$past(key)] == $past(prev[key]));
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !evt_irq) |=> evt_irq);
endmodule

// File: tb/test_kme_encoder.sv
module test_kme_encoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_rate = 1'b0;
    logic [11:0] col_in;
    logic [7:0]  row_drive;
    logic        evt_pop = 1'b0;
    logic [7:0]  evt_code;
    logic        evt_irq;
    logic        evt_overflow;
    logic [95:0] keys = '0;
    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    always_comb begin
        col_in = '0;
        for (int r = 0; r < 8; r++)
            if (row_drive[r]) col_in = col_in | keys[r*12 +: 12];
    end

    kme_encoder i_kme_encoder (
        .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .col_in(col_in),
        .row_drive(row_drive), .evt_pop(evt_pop), .evt_code(evt_code),
        .evt_irq(evt_irq), .evt_overflow(evt_overflow)
    );

    task automatic check(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_irq(int limit);
        for (int i = 0; i < limit && !evt_irq; i++) @(negedge clk);
    endtask

    task automatic pop_expect(string req, int exp);
        wait_irq(2000);
        check(req, int'(evt_irq), 1, "irq before pop");
        check(req, int'(evt_code), exp, "event code");
        evt_pop = 1'b1;
        @(negedge clk);
        evt_pop = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            evt_pop = evt_irq;
        end
        evt_pop = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11", int'(row_drive), 'hFF, "row_drive after reset");
        check("R11", int'(evt_irq), 0, "irq after reset");
        check("R11", int'(evt_overflow), 0, "overflow after reset");
    endtask

    task automatic t_single();
        keys[2*12+5] = 1'b1;
        pop_expect("R2", 8'h1D);
        @(negedge clk);
        check("R6", int'(evt_irq), 0, "irq after last pop");
        keys[2*12+5] = 1'b0;
        pop_expect("R2", 8'h9D);
    endtask

    task automatic t_order();
        keys[50] = 1'b1;
        keys[3]  = 1'b1;
        pop_expect("R4", 8'h03);
        pop_expect("R4", 8'h32);
        keys = '0;
        pop_expect("R4", 8'h83);
        pop_expect("R4", 8'hB2);
    endtask

    task automatic t_ghost();
        keys[0] = 1'b1;
        keys[1] = 1'b1;
        keys[12] = 1'b1;
        pop_expect("R5", 8'h00);
        pop_expect("R5", 8'h01);
        pop_expect("R5", 8'h0C);
        keys[13] = 1'b1;
        repeat (600) @(negedge clk);
        check("R5", int'(evt_irq), 0, "ghost corner gave no event");
        keys = '0;
        pop_expect("R5", 8'h80);
        pop_expect("R5", 8'h81);
        pop_expect("R5", 8'h8C);
        repeat (600) @(negedge clk);
        check("R5", int'(evt_irq), 0, "no release for unreported ghost");
    endtask

    task automatic t_debounce_rate();
        keys[95] = 1'b1;
        pop_expect("R3", 8'h5F);
        while (row_drive == 8'h01) @(negedge clk);
        while (row_drive != 8'h01) @(negedge clk);
        keys[5] = 1'b1;
        while (row_drive == 8'h01) @(negedge clk);
        while (row_drive != 8'h01) @(negedge clk);
        keys[5] = 1'b0;
        repeat (600) @(negedge clk);
        check("R3", int'(evt_irq), 0, "one-scan press ignored");
        begin
            int dwell = 0;
            while (row_drive != 8'h08) @(negedge clk);
            while (row_drive == 8'h08) begin dwell++; @(negedge clk); end
            check("R8", dwell, 1, "row dwell at full rate");
            half_rate = 1'b1;
            dwell = 0;
            while (row_drive != 8'h08) @(negedge clk);
            while (row_drive == 8'h08) begin dwell++; @(negedge clk); end
            check("R8", dwell, 2, "row dwell at half rate");
            check("R1", int'(row_drive), 'h10, "row after row 3");
            half_rate = 1'b0;
        end
        keys = '0;
        pop_expect("R3", 8'hDF);
    endtask

    task automatic t_sleep();
        repeat (600) @(negedge clk);
        check("R9", int'(row_drive), 'hFF, "sleep drives all rows");
        repeat (300) @(negedge clk);
        check("R9", int'(row_drive), 'hFF, "stays asleep when idle");
        keys[40] = 1'b1;
        @(negedge clk);
        check("R9", int'(row_drive), 'h01, "wake drives row 0");
        pop_expect("R9", 8'h28);
        keys = '0;
        pop_expect("R9", 8'hA8);
    endtask

    task automatic t_overflow();
        evt_pop = 1'b1;
        @(negedge clk);
        evt_pop = 1'b0;
        check("R10", int'(evt_irq), 0, "pop on empty queue");
        check("R10", int'(evt_overflow), 0, "pop on empty no overflow");
        for (int k = 84; k <= 92; k++) keys[k] = 1'b1;
        repeat (800) @(negedge clk);
        check("R7", int'(evt_overflow), 1, "overflow flag set");
        for (int k = 84; k <= 91; k++) pop_expect("R7", k);
        @(negedge clk);
        check("R6", int'(evt_irq), 0, "queue empty after 8 pops");
        keys = '0;
        drain();
        check("R7", int'(evt_overflow), 1, "overflow flag sticky");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_order();
        t_ghost();
        t_debounce_rate();
        t_sleep();
        t_overflow();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule